// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Qualifier

This block sits in the reference-clock domain of a frequency synthesizer. It watches two pulse trains: a reference train from the reference divider and a feedback train from the loop divider. Both are already synchronous to the oscillator clock. Each rising edge sets a pending flag, one per train. While exactly one flag is pending, the block drives a tri-state charge-pump command. The drive direction is chosen by a polarity bit, which lets the loop work with oscillators of either tuning slope. When both flags are set, they clear together.

For every comparison, the block counts how many oscillator cycles the single-flag error lasted. It uses these counts to keep a lock indication. A single wide error drops lock at once. Lock returns only after several consecutive narrow errors.

One shared output pin carries either the lock indication or a monitor copy of one of the two pulse trains. A power-save input idles the detector and holds the lock indication high. Leaving power save restarts comparison and qualification from a clean state.

Top module: `phase_lock_detector`

## Requirements
- R1: With `polarity`=1, `cp_oe`=1 and `cp_val`=1 while only the reference edge is pending. `cp_oe`=1 and `cp_val`=0 while only the feedback edge is pending. `cp_oe`=0 while neither or both are pending.
- R2: With `polarity`=0, the drive levels of R1 swap: `cp_val`=0 while only the reference edge is pending, and 1 while only the feedback edge is pending. The high-impedance condition is unchanged.
- R3: A rising edge seen at a clock edge sets its pending flag at that clock edge. At the clock edge after both flags are set, both are cleared. Edges arriving in the same cycle therefore set both flags for exactly one cycle, with no drive.
- R4: An error counts the cycles during which exactly one flag is pending. When this count reaches UNLOCK_W (default 3), lock is cleared at the next clock edge, without waiting for the comparison to end.
- R5: When both flags set, the comparison ends. If its error count is at most LOCK_W (default 2), it counts as good. Lock is set at the end of the QUAL_CNT-th (default 3) consecutive good comparison. A comparison wider than LOCK_W restarts the count.
- R6: With `out_sel`=1, `ld_mon` follows `ref_in` when `polarity`=1 and `fb_in` when `polarity`=0, combinationally.
- R7: With `out_sel`=0 and `pwr_on`=1, `ld_mon` shows the lock state (1 = locked).
- R8: While `pwr_on`=0, `cp_oe`=0, pulse edges are ignored, and `ld_mon` reads 1 when `out_sel`=0.
- R9: On the first cycle after `pwr_on` returns to 1, no flag is pending, the error and qualification counts are zero, and lock is 0.
- R10: After synchronous reset (`rst_n`=0 at a clock edge), `cp_oe`=0 and lock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference pulse train, synchronous to clk |
| fb_in | input | 1 | Feedback pulse train, synchronous to clk |
| polarity | input | 1 | Drive polarity and monitor source select |
| out_sel | input | 1 | Shared pin select: 1 = monitor pulse, 0 = lock indication |
| pwr_on | input | 1 | 1 = normal operation, 0 = power save |
| cp_oe | output | 1 | Charge-pump drive enable (0 = high impedance) |
| cp_val | output | 1 | Charge-pump drive level when enabled |
| ld_mon | output | 1 | Shared lock / monitor output |

## Verification
The assertions check these properties on every cycle:
- Both flags never stay set for two cycles.
- No drive is issued while both flags are set.
- Lock falls right after the error count reaches the unlock width.
- Lock only rises just after a comparison ends.
- The shared pin reads high in power save.
- The state is clean on the first cycle after power save.

Other behaviours need directed scenarios:
- Exact drive levels for each polarity and leading train.
- The number of good comparisons needed before lock returns.
- Whether edges are ignored during power save.
- Requalification after leaving power save.

The bench shows these by comparing against a cycle-by-cycle model.

// File: rtl/pd_pkg.sv
// Package pd_pkg
// Shared types for the phase detector. Assumes nothing beyond IEEE 1800-2017.
package pd_pkg;

    // Index of each pulse train in the edge-detector vector.
    localparam int CH_REF = 0;
    localparam int CH_FB  = 1;
    localparam int N_CH   = 2;

    // Pending-edge state of the detector.
    typedef struct packed {
        logic up;   // reference edge pending
        logic dn;   // feedback edge pending
    } pd_flags_t;

    // One flag pending means a phase error is being measured.
    function automatic logic pd_err(input pd_flags_t f);
        return f.up ^ f.dn;
    endfunction

    // Both flags pending means the comparison has ended.
    function automatic logic pd_done(input pd_flags_t f);
        return f.up & f.dn;
    endfunction

endpackage

// File: rtl/pd_edge.sv
// Module pd_edge
// Rising-edge detector, one channel per input bit.
// Assumes its inputs are already synchronous to clk.
// Keeps sampling during power save, so a level held across exit gives no false edge.
module pd_edge #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] sig_in,
    output logic [CH-1:0] rise
);
    logic [CH-1:0] prev_q;

    for (genvar i = 0; i < CH; i++) begin : g_ch
        // Hold the previous sample of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= sig_in[i];
        end

        // An edge is a high sample that follows a low one.
        assign rise[i] = sig_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pd_pfd.sv
// Module pd_pfd
// Two-flag phase-frequency detector core.
// Each flag sets on its own edge. Both clear together one cycle after both are set.
// Edges arriving in the clearing cycle seed the next comparison.
// Assumes edges are single-cycle, as produced by pd_edge.
module pd_pfd (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ref_rise,
    input  logic             fb_rise,
    output pd_pkg::pd_flags_t flags
);
    import pd_pkg::*;

    pd_flags_t flags_d;

    // Next-state of the flags.
    always_comb begin
        if (pd_done(flags)) begin
            flags_d.up = ref_rise;
            flags_d.dn = fb_rise;
        end else begin
            flags_d.up = flags.up | ref_rise;
            flags_d.dn = flags.dn | fb_rise;
        end
    end

    // Flag registers: cleared by reset or power save.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) flags <= '0;
        else                flags <= flags_d;
    end
endmodule

// File: rtl/pd_lock.sv
// Module pd_lock
// Measures error width in clock cycles and qualifies lock.
// A width reaching UNLOCK_W clears lock at once.
// QUAL_CNT consecutive comparisons no wider than LOCK_W set it.
// Assumes LOCK_W < UNLOCK_W.
module pd_lock #(
    parameter int UNLOCK_W = 3,
    parameter int LOCK_W   = 2,
    parameter int QUAL_CNT = 3,
    parameter int CNT_W    = $clog2(UNLOCK_W + 1),
    parameter int QUAL_W   = $clog2(QUAL_CNT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  pd_pkg::pd_flags_t flags,
    output logic              lock_q,
    output logic [CNT_W-1:0]  wid_cnt
);
    import pd_pkg::*;

    localparam logic [CNT_W:0]  UNLOCK_LIM = (CNT_W+1)'(UNLOCK_W);
    localparam logic [CNT_W:0]  LOCK_LIM   = (CNT_W+1)'(LOCK_W);
    localparam logic [QUAL_W:0] QUAL_LIM   = (QUAL_W+1)'(QUAL_CNT);

    logic [QUAL_W-1:0] good_q;
    logic [CNT_W:0]    wid_inc;
    logic [QUAL_W:0]   good_inc;

    // Incremented counts, one bit wider so the compare cannot wrap.
    always_comb begin
        wid_inc  = {1'b0, wid_cnt} + 1'b1;
        good_inc = {1'b0, good_q} + 1'b1;
    end

    // Width count, qualification count and lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            wid_cnt <= '0;
            good_q  <= '0;
            lock_q  <= 1'b0;
        end else if (pd_err(flags)) begin
            if (wid_inc >= UNLOCK_LIM) begin
                lock_q  <= 1'b0;
                good_q  <= '0;
                wid_cnt <= UNLOCK_LIM[CNT_W-1:0];
            end else begin
                wid_cnt <= wid_inc[CNT_W-1:0];
            end
        end else if (pd_done(flags)) begin
            wid_cnt <= '0;
            if ({1'b0, wid_cnt} <= LOCK_LIM) begin
                if (good_inc >= QUAL_LIM) begin
                    lock_q <= 1'b1;
                    good_q <= QUAL_LIM[QUAL_W-1:0];
                end else begin
                    good_q <= good_inc[QUAL_W-1:0];
                end
            end else begin
                good_q <= '0;
            end
        end
    end
endmodule

// File: rtl/pd_out.sv
// Module pd_out
// Output stage: polarity-controlled tri-state command and shared-pin selector.
// Purely combinational. The pin-level tri-state buffer lies outside this block.
module pd_out (
    input  pd_pkg::pd_flags_t flags,
    input  logic              run,
    input  logic              polarity,
    input  logic              out_sel,
    input  logic              lock_q,
    input  logic              ref_in,
    input  logic              fb_in,
    output logic              cp_oe,
    output logic              cp_val,
    output logic              ld_mon
);
    import pd_pkg::*;

    // Drive only during a one-sided error; the level follows polarity.
    always_comb begin
        cp_oe  = run & pd_err(flags);
        cp_val = cp_oe & (polarity ? flags.up : flags.dn);
    end

    // Shared pin: monitor pulse, or lock held high in power save.
    always_comb begin
        if (out_sel) ld_mon = polarity ? ref_in : fb_in;
        else         ld_mon = run ? lock_q : 1'b1;
    end
endmodule

// File: rtl/phase_lock_detector.sv
// Module phase_lock_detector
// Top level: edge detection, two-flag detector, lock qualifier and output stage.
// Assumes ref_in and fb_in are synchronous to clk.
// The timing check for Verilator is the companion bound checker pd_checker.
module phase_lock_detector #(
    parameter int UNLOCK_W = 3,
    parameter int LOCK_W   = 2,
    parameter int QUAL_CNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic polarity,
    input  logic out_sel,
    input  logic pwr_on,
    output logic cp_oe,
    output logic cp_val,
    output logic ld_mon
);
    import pd_pkg::*;

    localparam int CNT_W  = $clog2(UNLOCK_W + 1);
    localparam int QUAL_W = $clog2(QUAL_CNT + 1);

    logic [N_CH-1:0] sig_vec;
    logic [N_CH-1:0] rise_vec;
    pd_flags_t       flags;
    logic            up_q;
    logic            dn_q;
    logic            lock_q;
    logic [CNT_W-1:0] wid_cnt;

    assign sig_vec[CH_REF] = ref_in;
    assign sig_vec[CH_FB]  = fb_in;
    assign up_q = flags.up;
    assign dn_q = flags.dn;

    pd_edge #(.CH(N_CH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_vec),
        .rise   (rise_vec)
    );

    pd_pfd u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pwr_on),
        .ref_rise (rise_vec[CH_REF]),
        .fb_rise  (rise_vec[CH_FB]),
        .flags    (flags)
    );

    pd_lock #(
        .UNLOCK_W (UNLOCK_W),
        .LOCK_W   (LOCK_W),
        .QUAL_CNT (QUAL_CNT),
        .CNT_W    (CNT_W),
        .QUAL_W   (QUAL_W)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pwr_on),
        .flags   (flags),
        .lock_q  (lock_q),
        .wid_cnt (wid_cnt)
    );

    pd_out u_out (
        .flags    (flags),
        .run      (pwr_on),
        .polarity (polarity),
        .out_sel  (out_sel),
        .lock_q   (lock_q),
        .ref_in   (ref_in),
        .fb_in    (fb_in),
        .cp_oe    (cp_oe),
        .cp_val   (cp_val),
        .ld_mon   (ld_mon)
    );
endmodule

// File: rtl/pd_checker.sv
// Module pd_checker
// Temporal checks for phase_lock_detector, attached by bind.
module pd_checker #(
    parameter int UNLOCK_W = 3,
    parameter int CNT_W    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_on,
    input logic             out_sel,
    input logic             up_q,
    input logic             dn_q,
    input logic             lock_q,
    input logic [CNT_W-1:0] wid_cnt,
    input logic             cp_oe,
    input logic             ld_mon
);
    localparam logic [CNT_W-1:0] LAST_ERR = CNT_W'(UNLOCK_W - 1);

    // R3: both flags never stay set for two cycles.
    a_r3_both_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && dn_q) |=> !(up_q && dn_q));

    // R1: no drive while both flags are set.
    a_r1_no_drive_both: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && dn_q) |-> !cp_oe);

    // R4: lock falls right after the error count reaches the unlock width.
    a_r4_unlock_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && (up_q ^ dn_q) && wid_cnt == LAST_ERR) |=> !lock_q);

    // R5: lock only rises just after a comparison ends.
    a_r5_lock_after_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(up_q && dn_q));

    // R8: shared pin reads high in power save.
    a_r8_ps_lock_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_on && !out_sel) |-> ld_mon);

    // R8: no drive in power save.
    a_r8_ps_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> !cp_oe);

    // R9: clean state on the first cycle after power save.
    a_r9_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on) |-> (!up_q && !dn_q && !lock_q && wid_cnt == '0));
endmodule

bind phase_lock_detector pd_checker #(
    .UNLOCK_W (UNLOCK_W),
    .CNT_W    (CNT_W)
) u_pd_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_on  (pwr_on),
    .out_sel (out_sel),
    .up_q    (up_q),
    .dn_q    (dn_q),
    .lock_q  (lock_q),
    .wid_cnt (wid_cnt),
    .cp_oe   (cp_oe),
    .ld_mon  (ld_mon)
);

// File: tb/tb_phase_lock_detector.sv
module tb_phase_lock_detector;
    localparam int UNLOCK_W = 3;
    localparam int LOCK_W   = 2;
    localparam int QUAL_CNT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic polarity = 1'b1;
    logic out_sel = 1'b0;
    logic pwr_on = 1'b1;
    logic cp_oe;
    logic cp_val;
    logic ld_mon;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Behavioural model state.
    int m_up = 0, m_dn = 0, m_wid = 0, m_good = 0, m_lock = 0;
    int m_rp = 0, m_fp = 0;

    always #5 clk = ~clk;

    phase_lock_detector #(
        .UNLOCK_W (UNLOCK_W),
        .LOCK_W   (LOCK_W),
        .QUAL_CNT (QUAL_CNT)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .fb_in    (fb_in),
        .polarity (polarity),
        .out_sel  (out_sel),
        .pwr_on   (pwr_on),
        .cp_oe    (cp_oe),
        .cp_val   (cp_val),
        .ld_mon   (ld_mon)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model by one clock edge using the inputs now applied.
    task automatic model_step();
        int rr, fr, ou, od;
        rr = (ref_in && !m_rp) ? 1 : 0;
        fr = (fb_in && !m_fp) ? 1 : 0;
        if (!rst_n) begin
            m_rp = 0; m_fp = 0;
            m_up = 0; m_dn = 0; m_wid = 0; m_good = 0; m_lock = 0;
            return;
        end
        m_rp = int'(ref_in);
        m_fp = int'(fb_in);
        if (!pwr_on) begin
            m_up = 0; m_dn = 0; m_wid = 0; m_good = 0; m_lock = 0;
            return;
        end
        ou = m_up; od = m_dn;
        if (ou != od) begin
            m_wid++;
            if (m_wid >= UNLOCK_W) begin m_lock = 0; m_good = 0; m_wid = UNLOCK_W; end
        end else if (ou == 1 && od == 1) begin
            if (m_wid <= LOCK_W) begin
                m_good++;
                if (m_good >= QUAL_CNT) begin m_lock = 1; m_good = QUAL_CNT; end
            end else begin
                m_good = 0;
            end
            m_wid = 0;
        end
        if (ou == 1 && od == 1) begin m_up = rr; m_dn = fr; end
        else begin m_up = ou | rr; m_dn = od | fr; end
    endtask

    // Compare all outputs with the model.
    task automatic compare_all();
        int e_oe, e_val, e_ld;
        string t_cp, t_ld;
        e_oe  = (pwr_on && m_up != m_dn) ? 1 : 0;
        e_val = (e_oe == 1) ? (polarity ? m_up : m_dn) : 0;
        if (out_sel) e_ld = polarity ? int'(ref_in) : int'(fb_in);
        else         e_ld = pwr_on ? m_lock : 1;
        t_cp = !pwr_on ? "R8" : (polarity ? "R1" : "R2");
        t_ld = out_sel ? "R6" : (pwr_on ? "R7" : "R8");
        check(int'(cp_oe) == e_oe, {t_cp, " cp_oe"}, int'(cp_oe), e_oe);
        check(int'(cp_val) == e_val, {t_cp, " cp_val"}, int'(cp_val), e_val);
        check(int'(ld_mon) == e_ld, {t_ld, " ld_mon"}, int'(ld_mon), e_ld);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    // One comparison: the leading train pulses at t=0, the other dly cycles later.
    task automatic pair(input int dly, input bit ref_first, input int period);
        for (int t = 0; t < period; t++) begin
            ref_in = ref_first ? (t < 2) : (t >= dly && t < dly + 2);
            fb_in  = ref_first ? (t >= dly && t < dly + 2) : (t < 2);
            tick();
            if (pwr_on && t == 0 && dly > 0)
                check(cp_oe && (cp_val == (ref_first ? polarity : !polarity)),
                      polarity ? "R1 leading drive" : "R2 leading drive",
                      int'(cp_val), int'(ref_first ? polarity : !polarity));
            if (pwr_on && t == dly)
                check(!cp_oe, "R3 both set no drive", int'(cp_oe), 0);
            if (pwr_on && t == dly + 1)
                check(!cp_oe, "R3 cleared after both", int'(cp_oe), 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R10: reset state.
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(!cp_oe, "R10 reset no drive", int'(cp_oe), 0);
        check(!ld_mon, "R10 reset lock low", int'(ld_mon), 0);

        // R5: qualification with the reference leading by one cycle.
        polarity = 1'b1;
        pair(1, 1, 6);
        pair(1, 1, 6);
        check(!ld_mon, "R5 two good not locked", int'(ld_mon), 0);
        pair(1, 1, 6);
        check(ld_mon, "R5 third good locks", int'(ld_mon), 1);

        // R4: one wide error unlocks.
        pair(3, 1, 7);
        check(!ld_mon, "R4 wide error unlocks", int'(ld_mon), 0);

        // R5: requalify with the feedback leading by two cycles.
        pair(2, 0, 6);
        pair(2, 0, 6);
        check(!ld_mon, "R5 requal incomplete", int'(ld_mon), 0);
        pair(2, 0, 6);
        check(ld_mon, "R5 requal done", int'(ld_mon), 1);

        // R2: swapped polarity; R3: coincident edges.
        polarity = 1'b0;
        pair(2, 1, 6);
        pair(1, 0, 6);
        pair(0, 1, 5);
        check(ld_mon, "R7 lock held", int'(ld_mon), 1);

        // R6: monitor selection.
        out_sel = 1'b1;
        pair(2, 1, 6);
        polarity = 1'b1;
        pair(2, 0, 6);
        @(negedge clk);
        ref_in = 1'b1; fb_in = 1'b0; polarity = 1'b1;
        #1 check(ld_mon, "R6 shows reference", int'(ld_mon), 1);
        polarity = 1'b0;
        #1 check(!ld_mon, "R6 shows feedback", int'(ld_mon), 0);
        ref_in = 1'b0; polarity = 1'b1;
        tick();

        // R8: power save.
        out_sel = 1'b0;
        pwr_on = 1'b0;
        tick();
        check(ld_mon, "R8 lock forced high", int'(ld_mon), 1);
        pair(2, 1, 6);
        check(!cp_oe, "R8 no drive", int'(cp_oe), 0);

        // R9: clean restart.
        pwr_on = 1'b1;
        tick();
        check(!ld_mon, "R9 lock cleared on exit", int'(ld_mon), 0);
        check(!cp_oe, "R9 no pending flag", int'(cp_oe), 0);
        pair(1, 1, 6);
        pair(1, 1, 6);
        pair(1, 1, 6);
        check(ld_mon, "R9 requalified", int'(ld_mon), 1);

        // R10: reset mid-lock.
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        check(!ld_mon, "R10 reset clears lock", int'(ld_mon), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule